// File: doc/BRIEF.md
# Dual-Clock Byte-Plus-Parity FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer for 9-bit words. It has a write port and a read port, and each port runs on its own free-running clock. A pair of enables of opposite polarity gates each port. On the write side the active-high enable does a second job. When it is held low while the active-low enable is asserted, the data bus loads the two threshold offsets instead of writing a word into the FIFO. A separate output-enable input decides whether the read data is presented. When it is not, the data bus is forced to zero and a valid flag drops.

The block has four status outputs: full, empty, almost-full and almost-empty. The two almost flags compare the current fill level against offsets that can be programmed. The parameter `ASYNC` selects how the pointers pass between the two domains. When it is 1, each pointer crosses as Gray code through a two-flop synchronizer, so the read clock and write clock may be unrelated. When it is 0, the two clocks must be one clock and the pointers are used directly, with no synchronizer latency.

Top module: `fifo9_dual`

## Requirements
- R1: A word is stored on a rising write-clock edge exactly when `wr_en1_n`=0, `wr_en2_ld`=1 and `full`=0. Back-to-back cycles store a word every cycle. Words leave in the order they were written.
- R2: A read occurs on a rising read-clock edge exactly when `rd_en1_n`=0, `rd_en2`=1 and `empty`=0. The word read becomes visible on `rd_data` after that same edge and holds until the next read.
- R3: A write attempt while `full`=1 changes nothing. The write pointer stays put and no stored word is overwritten.
- R4: A read attempt while `empty`=1 changes nothing. The read pointer stays put and `rd_data` keeps its previous word.
- R5: `full`=1 exactly when the FIFO holds 2^AW words. `empty`=1 exactly when it holds none. Both are evaluated in single-clock mode.
- R6: `almost_empty`=1 when the fill level is at most the almost-empty offset. `almost_full`=1 when the fill level plus the almost-full offset is at least 2^AW.
- R7: When `wr_en1_n`=0 and `wr_en2_ld`=0, `wr_data[AW:0]` is loaded into an offset register and no word is written. Successive loads alternate, almost-empty offset first, then almost-full offset, then almost-empty again.
- R8: With `out_en`=0, `rd_data` is all zeros and `rd_valid`=0. With `out_en`=1, `rd_valid`=1 and `rd_data` shows the last word read.
- R9: Synchronous active-high `rst` clears both pointers, so `empty`=1, `almost_empty`=1 and `full`=0. It sets both offsets to their defaults (2 each) and points the next load at the almost-empty offset.
- R10: With `ASYNC`=1 and unrelated clocks, every written word is read exactly once, in order. Pointers cross as Gray code, so each registered pointer code changes by at most one bit per edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, sampled in both domains |
| wr_en1_n | input | 1 | Active-low write/load enable |
| wr_en2_ld | input | 1 | High: write a word; low: load an offset |
| wr_data | input | DW | Write data, also the offset value source |
| rd_en1_n | input | 1 | Active-low read enable |
| rd_en2 | input | 1 | Active-high read enable |
| out_en | input | 1 | Presents read data when high |
| rd_data | output | DW | Last word read, or zero when not enabled |
| rd_valid | output | 1 | High while rd_data is presented |
| full | output | 1 | FIFO holds 2^AW words (write domain) |
| empty | output | 1 | FIFO holds no word (read domain) |
| almost_full | output | 1 | Fill level within the almost-full offset of capacity |
| almost_empty | output | 1 | Fill level at or below the almost-empty offset |

## Verification
On every edge, the checker confirms four things. Blocked writes at full and blocked reads at empty leave the pointers frozen. Accepted operations advance the pointers by exactly one. The Gray-coded write pointer never moves by more than one bit. The flag implications and the post-reset empty state always hold. Some behaviour only the bench scenarios can show: the exact data order, the alternating offset-load sequence, the threshold crossings under reprogrammed offsets, the output-enable gating, and intact transfer between two unrelated clocks.

// File: rtl/fifo9_pkg.sv
package fifo9_pkg;
  // which offset register the next load strobe targets
  typedef enum logic {
    SEL_AE = 1'b0,
    SEL_AF = 1'b1
  } off_sel_e;
endpackage

// File: rtl/fifo9_ram.sv
module fifo9_ram #(
  parameter int DW = 9,
  parameter int AW = 4
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rd_clk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read port, no reset, so it maps onto block RAM
  always_ff @(posedge rd_clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/fifo9_ptr_sync.sv
module fifo9_ptr_sync #(
  parameter int W     = 5,
  parameter bit ASYNC = 1'b1
) (
  input  logic         dst_clk,
  input  logic         rst,
  input  logic [W-1:0] src_gray,
  output logic [W-1:0] dst_bin
);
  logic [W-1:0] g;

  generate
    if (ASYNC) begin : g_async
      logic [W-1:0] s1, s2;
      always_ff @(posedge dst_clk) begin
        if (rst) begin
          s1 <= '0;
          s2 <= '0;
        end else begin
          s1 <= src_gray;
          s2 <= s1;
        end
      end
      assign g = s2;
    end else begin : g_same
      assign g = src_gray;
    end
  endgenerate

  always_comb begin
    dst_bin[W-1] = g[W-1];
    for (int i = W - 2; i >= 0; i--) dst_bin[i] = dst_bin[i+1] ^ g[i];
  end
endmodule

// File: rtl/fifo9_offsets.sv
module fifo9_offsets
  import fifo9_pkg::*;
#(
  parameter int AW     = 4,
  parameter int AE_DEF = 2,
  parameter int AF_DEF = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ld,
  input  logic [AW:0] din,
  output logic [AW:0] ae_off,
  output logic [AW:0] af_off
);
  off_sel_e sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      ae_off <= (AW+1)'(AE_DEF);
      af_off <= (AW+1)'(AF_DEF);
      sel    <= SEL_AE;
    end else if (ld) begin
      if (sel == SEL_AE) begin
        ae_off <= din;
        sel    <= SEL_AF;
      end else begin
        af_off <= din;
        sel    <= SEL_AE;
      end
    end
  end
endmodule

// File: rtl/fifo9_dual.sv
module fifo9_dual #(
  parameter int DW     = 9,
  parameter int AW     = 4,
  parameter bit ASYNC  = 1'b1,
  parameter int AE_DEF = 2,
  parameter int AF_DEF = 2
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst,
  input  logic          wr_en1_n,
  input  logic          wr_en2_ld,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en1_n,
  input  logic          rd_en2,
  input  logic          out_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          full,
  output logic          empty,
  output logic          almost_full,
  output logic          almost_empty
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;

  logic          wr_req, ld_req, rd_req, wr_go, rd_go;
  logic [PW-1:0] wptr_bin, wptr_gray, wptr_nxt;
  logic [PW-1:0] rptr_bin, rptr_gray, rptr_nxt;
  logic [PW-1:0] rptr_w_bin, wptr_r_bin;
  logic [PW-1:0] wcount, rcount;
  logic [PW-1:0] ae_off, af_off;
  logic [DW-1:0] rd_q;

  // ---------------- write domain ----------------
  assign wr_req   = !wr_en1_n && wr_en2_ld;
  assign ld_req   = !wr_en1_n && !wr_en2_ld;
  assign wr_go    = wr_req && !full;
  assign wptr_nxt = wptr_bin + PW'(1);

  always_ff @(posedge wr_clk) begin
    if (rst) begin
      wptr_bin  <= '0;
      wptr_gray <= '0;
    end else if (wr_go) begin
      wptr_bin  <= wptr_nxt;
      wptr_gray <= wptr_nxt ^ (wptr_nxt >> 1);
    end
  end

  fifo9_ptr_sync #(.W(PW), .ASYNC(ASYNC)) u_rsync (
    .dst_clk (wr_clk),
    .rst     (rst),
    .src_gray(rptr_gray),
    .dst_bin (rptr_w_bin)
  );

  fifo9_offsets #(.AW(AW), .AE_DEF(AE_DEF), .AF_DEF(AF_DEF)) u_off (
    .clk   (wr_clk),
    .rst   (rst),
    .ld    (ld_req),
    .din   (wr_data[PW-1:0]),
    .ae_off(ae_off),
    .af_off(af_off)
  );

  assign wcount      = wptr_bin - rptr_w_bin;
  assign full        = wcount[AW];
  assign almost_full = ({1'b0, wcount} + {1'b0, af_off}) >= (PW+1)'(DEPTH);

  // ---------------- read domain ----------------
  assign rd_req   = !rd_en1_n && rd_en2;
  assign rd_go    = rd_req && !empty;
  assign rptr_nxt = rptr_bin + PW'(1);

  always_ff @(posedge rd_clk) begin
    if (rst) begin
      rptr_bin  <= '0;
      rptr_gray <= '0;
    end else if (rd_go) begin
      rptr_bin  <= rptr_nxt;
      rptr_gray <= rptr_nxt ^ (rptr_nxt >> 1);
    end
  end

  fifo9_ptr_sync #(.W(PW), .ASYNC(ASYNC)) u_wsync (
    .dst_clk (rd_clk),
    .rst     (rst),
    .src_gray(wptr_gray),
    .dst_bin (wptr_r_bin)
  );

  assign rcount       = wptr_r_bin - rptr_bin;
  assign empty        = (rcount == '0);
  assign almost_empty = (rcount <= ae_off);

  // ---------------- storage ----------------
  fifo9_ram #(.DW(DW), .AW(AW)) u_ram (
    .wr_clk(wr_clk),
    .we    (wr_go),
    .waddr (wptr_bin[AW-1:0]),
    .wdata (wr_data),
    .rd_clk(rd_clk),
    .re    (rd_go),
    .raddr (rptr_bin[AW-1:0]),
    .rdata (rd_q)
  );

  assign rd_valid = out_en;
  assign rd_data  = out_en ? rd_q : '0;
endmodule

// File: rtl/fifo9_chk.sv
module fifo9_chk #(
  parameter int PW = 5
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          rst,
  input logic          wr_req,
  input logic          rd_req,
  input logic          full,
  input logic          empty,
  input logic          almost_full,
  input logic          almost_empty,
  input logic [PW-1:0] wptr,
  input logic [PW-1:0] rptr,
  input logic [PW-1:0] wgray
);
  // R3
  a_r3_no_overflow: assert property (@(posedge wr_clk) disable iff (rst)
    (wr_req && full) |=> (wptr == $past(wptr)));
  // R4
  a_r4_no_underflow: assert property (@(posedge rd_clk) disable iff (rst)
    (rd_req && empty) |=> (rptr == $past(rptr)));
  // R1
  a_r1_write_advances: assert property (@(posedge wr_clk) disable iff (rst)
    (wr_req && !full) |=> (wptr == PW'($past(wptr) + 1'b1)));
  // R2
  a_r2_read_advances: assert property (@(posedge rd_clk) disable iff (rst)
    (rd_req && !empty) |=> (rptr == PW'($past(rptr) + 1'b1)));
  // R10
  a_r10_gray_step: assert property (@(posedge wr_clk) disable iff (rst)
    $countones(wgray ^ $past(wgray)) <= 1);
  // R6
  a_r6_full_implies_af: assert property (@(posedge wr_clk) disable iff (rst)
    full |-> almost_full);
  // R6
  a_r6_empty_implies_ae: assert property (@(posedge rd_clk) disable iff (rst)
    empty |-> almost_empty);
  // R9
  a_r9_reset_empty: assert property (@(posedge rd_clk) disable iff (rst)
    $past(rst) |-> (empty && almost_empty));
endmodule

bind fifo9_dual fifo9_chk #(.PW(AW + 1)) chk_i (
  .wr_clk      (wr_clk),
  .rd_clk      (rd_clk),
  .rst         (rst),
  .wr_req      (wr_req),
  .rd_req      (rd_req),
  .full        (full),
  .empty       (empty),
  .almost_full (almost_full),
  .almost_empty(almost_empty),
  .wptr        (wptr_bin),
  .rptr        (rptr_bin),
  .wgray       (wptr_gray)
);

// File: tb/fifo9_dual_tb_top.sv
module fifo9_dual_tb_top;
  localparam int DW = 9;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;
  localparam int NASYNC = 40;

  logic clk = 1'b0, rclk = 1'b0, rst = 1'b1;
  always #2.5 clk = ~clk;    // 200 MHz
  always #3.5 rclk = ~rclk;  // unrelated read clock for the async instance

  int errors = 0, checks = 0;
  string tag = "R9";

  // ---- single-clock instance, compared against the model every clock ----
  logic wen1n = 1'b1, wen2 = 1'b1, ren1n = 1'b1, ren2 = 1'b1, oe = 1'b0;
  logic [DW-1:0] wd = '0, rdat;
  logic rval, fl, em, afl, ael;

  fifo9_dual #(.DW(DW), .AW(AW), .ASYNC(1'b0)) dut_i (
    .wr_clk(clk), .rd_clk(clk), .rst(rst),
    .wr_en1_n(wen1n), .wr_en2_ld(wen2), .wr_data(wd),
    .rd_en1_n(ren1n), .rd_en2(ren2), .out_en(oe),
    .rd_data(rdat), .rd_valid(rval), .full(fl), .empty(em),
    .almost_full(afl), .almost_empty(ael)
  );

  // ---- asynchronous instance ----
  logic a_wen1n = 1'b1, a_ren1n = 1'b1;
  logic [DW-1:0] a_wd = '0, a_rdat;
  logic a_rval, a_fl, a_em, a_afl, a_ael;

  fifo9_dual #(.DW(DW), .AW(AW), .ASYNC(1'b1)) dut_a (
    .wr_clk(clk), .rd_clk(rclk), .rst(rst),
    .wr_en1_n(a_wen1n), .wr_en2_ld(1'b1), .wr_data(a_wd),
    .rd_en1_n(a_ren1n), .rd_en2(1'b1), .out_en(1'b1),
    .rd_data(a_rdat), .rd_valid(a_rval), .full(a_fl), .empty(a_em),
    .almost_full(a_afl), .almost_empty(a_ael)
  );

  // ---- behavioural reference ----
  int q[$];
  int m_ae = 2, m_af = 2, m_sel = 0, m_rd = 0;
  bit m_known = 1'b0;

  task automatic expect_eq(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    expect_eq("R5 full", int'(fl), int'(q.size() == DEPTH));
    expect_eq("R5 empty", int'(em), int'(q.size() == 0));
    expect_eq("R6 almost_full", int'(afl), int'(q.size() + m_af >= DEPTH));
    expect_eq("R6 almost_empty", int'(ael), int'(q.size() <= m_ae));
    expect_eq("R8 rd_valid", int'(rval), int'(oe));
    if (!oe) expect_eq("R8 rd_data gated", int'(rdat), 0);
    else if (m_known) expect_eq("R2 rd_data", int'(rdat), m_rd);
  endtask

  // one clock: check, drive, then advance the model at the edge
  task automatic step(bit w1n, bit w2, int d, bit r1n, bit r2, bit o);
    bit do_ld, do_w, do_r;
    @(negedge clk);
    compare();
    wen1n = w1n; wen2 = w2; wd = DW'(d); ren1n = r1n; ren2 = r2; oe = o;
    do_ld = !w1n && !w2;
    do_w  = !w1n && w2 && (q.size() < DEPTH);
    do_r  = !r1n && r2 && (q.size() > 0);
    @(posedge clk);
    if (do_r) begin
      m_rd = q.pop_front();
      m_known = 1'b1;
    end
    if (do_w) q.push_back(d & ((1 << DW) - 1));
    if (do_ld) begin
      if (m_sel == 0) m_ae = d & ((1 << (AW + 1)) - 1);
      else            m_af = d & ((1 << (AW + 1)) - 1);
      m_sel ^= 1;
    end
  endtask

  task automatic wr(int d);       step(1'b0, 1'b1, d, 1'b1, 1'b1, 1'b1); endtask
  task automatic rd();            step(1'b1, 1'b1, 0, 1'b0, 1'b1, 1'b1); endtask
  task automatic ld(int d);       step(1'b0, 1'b0, d, 1'b1, 1'b1, 1'b1); endtask
  task automatic idle(bit o);     step(1'b1, 1'b1, 0, 1'b1, 1'b1, o);    endtask

  task automatic main_seq();
    // R9: reset state (checked by the first compares)
    tag = "R9";
    idle(1'b0); idle(1'b0);
    // R8: gated output
    tag = "R8";
    idle(1'b0); idle(1'b1); idle(1'b0);
    // R1: continuous fill, one word per cycle
    tag = "R1";
    for (int i = 0; i < DEPTH; i++) wr(i * 5 + 1);
    // R3: overflow attempts ignored
    tag = "R3";
    wr(9'h1FF); wr(9'h1AA); idle(1'b1);
    // R2: drain in order, then the R4 underflow attempts keep rd_data
    tag = "R2";
    for (int i = 0; i < DEPTH; i++) rd();
    tag = "R4";
    rd(); rd(); idle(1'b1);
    // R7: program offsets ae=5, af=3, then a third load returns to ae
    tag = "R7";
    ld(5); ld(3); idle(1'b1);
    for (int i = 0; i < DEPTH; i++) wr(100 + i);
    for (int i = 0; i < DEPTH; i++) rd();
    ld(1); idle(1'b1);
    wr(7); wr(8); idle(1'b1); rd(); rd(); idle(1'b1);
    // R8: output gating while words move
    tag = "R8";
    wr(33); rd(); idle(1'b0); idle(1'b1); idle(1'b0);
    // R1: random mix of simultaneous reads and writes
    tag = "R1";
    for (int i = 0; i < 400; i++)
      step(1'($urandom_range(0, 2) == 0), 1'b1, int'($urandom_range(0, 511)),
           1'($urandom_range(0, 2) == 0), 1'($urandom_range(0, 5) != 0),
           1'($urandom_range(0, 4) != 0));
    idle(1'b1);
  endtask

  // ---- async transfer: writer on clk, reader on rclk ----
  int a_got = 0;

  task automatic async_wr();
    int n = 0;
    while (n < NASYNC) begin
      @(negedge clk);
      if (!a_fl && ($urandom_range(0, 3) != 0)) begin
        a_wen1n = 1'b0;
        a_wd = DW'(n * 7 + 3);
        n++;
      end else a_wen1n = 1'b1;
    end
    @(negedge clk);
    a_wen1n = 1'b1;
  endtask

  task automatic async_rd();
    bit pend = 1'b0;
    while (a_got < NASYNC) begin
      @(negedge rclk);
      if (pend) begin
        tag = "R10";
        expect_eq("R10 async order", int'(a_rdat), (a_got * 7 + 3) & 511);
        a_got++;
      end
      pend = !a_em && (a_got + int'(pend) < NASYNC) && ($urandom_range(0, 2) != 0);
      // a read issued now completes one read edge later
      if (pend && a_got >= NASYNC) pend = 1'b0;
      a_ren1n = !pend;
    end
    @(negedge rclk);
    a_ren1n = 1'b1;
  endtask

  bit done = 1'b0;

  initial begin
    rst = 1'b1;
    repeat (12) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    fork
      main_seq();
      async_wr();
      async_rd();
    join
    repeat (6) @(negedge rclk);
    tag = "R10";
    expect_eq("R10 async words received", a_got, NASYNC);
    expect_eq("R10 async empty after drain", int'(a_em), 1);
    repeat (6) @(negedge clk);
    expect_eq("R10 async not full after drain", int'(a_fl), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5ns * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule